// File: doc/BRIEF.md
# Processor Status Register with Low-Power Controls

This block holds the processor status word. It keeps the four arithmetic condition flags (carry, zero, negative, overflow), the global interrupt enable, and four bits that set the low-power state. The low-power bits are core-off, oscillator-off and a two-bit clock-generator control. The ALU reports each result together with its carry-out and operand signs, and the block derives the flags from these. Software can load the whole word in one cycle. The interrupt controller pulses a strobe when it accepts an interrupt. The return-from-interrupt path supplies the saved word that was popped from the stack.

Accepting an interrupt has automatic effects. It clears the global enable and wakes the core. When the interrupt comes from an external source, it also restarts the oscillator. A return-from-interrupt restores the saved word, so the power state from before the interrupt comes back, and it sets the global enable again. The power bits drive three registered outputs straight from the register: the core halt signal, the oscillator-off signal and the clock-generator control.

Top module: `cpu_status_reg`

## Requirements
- R1: While `rst` is high at a clock edge, the register becomes 0x0000, and `core_halt`, `osc_off` and `clk_gen_ctl` all read 0.
- R2: Bits 15 to 9 of `sr_q` always read zero. Any value written to those bits, by a software write or by a restore, has no effect.
- R3: An ALU update (`alu_valid`) sets the flags at the next edge. Bit 0 takes `alu_cout`, bit 1 is set when `alu_res` is zero, and bit 2 takes the sign of `alu_res`. The update does not change bits 3 to 7.
- R4: Bit 8 is the overflow flag. For an add (`alu_sub`=0), it is set when both operands have the same sign and the result sign differs from it. For a subtract, it is set when the operand signs differ and the result sign differs from the sign of `alu_a`. In every other case it is cleared.
- R5: A software write (`sw_we`) loads `sw_data[8:0]` at the next edge. The outputs follow the register: `core_halt` is bit 4, `osc_off` is bit 5, and `clk_gen_ctl` is {bit 7, bit 6}.
- R6: When a software write and an ALU update arrive in the same cycle, the software write wins and the ALU flags are discarded.
- R7: An interrupt strobe (`irq_take`) is accepted only while bit 3 (global enable) is set. When accepted, it clears bit 3 and bit 4 at the next edge and leaves all other bits unchanged.
- R8: An accepted interrupt with `irq_ext` high also clears bit 5. With `irq_ext` low, bit 5 keeps its value.
- R9: An interrupt strobe that arrives while bit 3 is clear has no effect on the register.
- R10: A return-from-interrupt (`reti_valid`) loads `reti_data[8:0]` with bit 3 forced to 1. This restores the saved low-power bits.
- R11: An accepted interrupt takes priority over a same-cycle software write for bits 3, 4 and 5. The written value still lands in the remaining bits.
- R12: A return-from-interrupt takes priority over a same-cycle software write and ALU update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_valid | input | 1 | ALU result valid this cycle; update flags |
| alu_sub | input | 1 | 1 = subtract (a - b), 0 = add |
| alu_a_sign | input | 1 | Sign bit of the first operand |
| alu_b_sign | input | 1 | Sign bit of the second operand |
| alu_res | input | DATA_W | ALU result |
| alu_cout | input | 1 | ALU carry-out |
| sw_we | input | 1 | Software write of the whole status word |
| sw_data | input | 16 | Value written by software |
| irq_take | input | 1 | Interrupt accept strobe |
| irq_ext | input | 1 | Accepted interrupt comes from an external source |
| reti_valid | input | 1 | Return-from-interrupt restore |
| reti_data | input | 16 | Saved status word popped from the stack |
| sr_q | output | 16 | Current status register value |
| core_halt | output | 1 | Halt instruction execution |
| osc_off | output | 1 | Stop the low-frequency oscillator |
| clk_gen_ctl | output | 2 | Clock-generator control bits |

## Verification
The flag logic is tested with adds and subtracts whose results overflow positive, overflow negative, come out zero with a carry-out, or stay in range. These cases separate overflow from negative and carry, and separate the subtract sign rule from the add rule. Interrupt strobes are tested with the global enable on and off, and with the external qualifier high and low. This shows which power bits a wake clears and confirms that a masked strobe changes nothing. Same-cycle collisions of interrupt, restore, software write and ALU update are tested to check the priority order bit by bit.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int SR_W = 16;
  localparam int BIT_C = 0;
  localparam int BIT_Z = 1;
  localparam int BIT_N = 2;
  localparam int BIT_GIE = 3;
  localparam int BIT_CPUOFF = 4;
  localparam int BIT_OSCOFF = 5;
  localparam int BIT_SCG0 = 6;
  localparam int BIT_SCG1 = 7;
  localparam int BIT_V = 8;
  localparam logic [SR_W-1:0] IMPL_MASK = 16'h01FF;

  typedef struct packed {
    logic v;
    logic n;
    logic z;
    logic c;
  } alu_flags_t;
endpackage

// File: rtl/psr_flag_calc.sv
module psr_flag_calc
  import psr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              sub,
  input  logic              a_sign,
  input  logic              b_sign,
  input  logic [DATA_W-1:0] res,
  input  logic              cout,
  output alu_flags_t        flags
);
  localparam int MSB = DATA_W - 1;
  logic b_eff;

  // Subtraction adds the inverted second operand, so its sign flips.
  assign b_eff = sub ? ~b_sign : b_sign;

  always_comb begin
    flags.c = cout;
    flags.z = (res == '0);
    flags.n = res[MSB];
    flags.v = (a_sign == b_eff) && (res[MSB] != a_sign);
  end
endmodule

// File: rtl/psr_src_mux.sv
module psr_src_mux
  import psr_pkg::*;
(
  input  logic [SR_W-1:0] cur,
  input  logic            reti_valid,
  input  logic [SR_W-1:0] reti_data,
  input  logic            sw_we,
  input  logic [SR_W-1:0] sw_data,
  input  logic            alu_valid,
  input  alu_flags_t      flags,
  output logic [SR_W-1:0] base
);
  // Priority: restore, then software write, then ALU update, then hold.
  always_comb begin
    base = cur;
    if (reti_valid) begin
      base = reti_data;
      base[BIT_GIE] = 1'b1;
    end else if (sw_we) begin
      base = sw_data;
    end else if (alu_valid) begin
      base[BIT_C] = flags.c;
      base[BIT_Z] = flags.z;
      base[BIT_N] = flags.n;
      base[BIT_V] = flags.v;
    end
    base = base & IMPL_MASK;
  end
endmodule

// File: rtl/psr_entry_ovr.sv
module psr_entry_ovr
  import psr_pkg::*;
(
  input  logic [SR_W-1:0] base,
  input  logic            gie_now,
  input  logic            irq_take,
  input  logic            irq_ext,
  output logic [SR_W-1:0] nxt
);
  logic accepted;
  assign accepted = irq_take & gie_now;

  // Interrupt entry overrides any other source for the bits it touches.
  always_comb begin
    nxt = base;
    if (accepted) begin
      nxt[BIT_GIE] = 1'b0;
      nxt[BIT_CPUOFF] = 1'b0;
      if (irq_ext) nxt[BIT_OSCOFF] = 1'b0;
    end
  end
endmodule

// File: rtl/cpu_status_reg.sv
module cpu_status_reg
  import psr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alu_valid,
  input  logic              alu_sub,
  input  logic              alu_a_sign,
  input  logic              alu_b_sign,
  input  logic [DATA_W-1:0] alu_res,
  input  logic              alu_cout,
  input  logic              sw_we,
  input  logic [15:0]       sw_data,
  input  logic              irq_take,
  input  logic              irq_ext,
  input  logic              reti_valid,
  input  logic [15:0]       reti_data,
  output logic [15:0]       sr_q,
  output logic              core_halt,
  output logic              osc_off,
  output logic [1:0]        clk_gen_ctl
);
  logic [SR_W-1:0] sr_r;
  logic [SR_W-1:0] base;
  logic [SR_W-1:0] nxt;
  alu_flags_t      flags;

  psr_flag_calc #(.DATA_W(DATA_W)) u_flags (
    .sub(alu_sub), .a_sign(alu_a_sign), .b_sign(alu_b_sign),
    .res(alu_res), .cout(alu_cout), .flags(flags)
  );

  psr_src_mux u_mux (
    .cur(sr_r), .reti_valid(reti_valid), .reti_data(reti_data),
    .sw_we(sw_we), .sw_data(sw_data), .alu_valid(alu_valid),
    .flags(flags), .base(base)
  );

  psr_entry_ovr u_entry (
    .base(base), .gie_now(sr_r[BIT_GIE]), .irq_take(irq_take),
    .irq_ext(irq_ext), .nxt(nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) sr_r <= '0;
    else     sr_r <= nxt & IMPL_MASK;
  end

  assign sr_q        = sr_r;
  assign core_halt   = sr_r[BIT_CPUOFF];
  assign osc_off     = sr_r[BIT_OSCOFF];
  assign clk_gen_ctl = {sr_r[BIT_SCG1], sr_r[BIT_SCG0]};
endmodule

// File: rtl/psr_checker.sv
module psr_checker (
  input logic        clk,
  input logic        rst,
  input logic        alu_valid,
  input logic        alu_sub,
  input logic        alu_a_sign,
  input logic        alu_b_sign,
  input logic        alu_res_msb,
  input logic        sw_we,
  input logic        irq_take,
  input logic        irq_ext,
  input logic        reti_valid,
  input logic [15:0] sr_q
);
  logic no_src;
  assign no_src = !alu_valid && !sw_we && !reti_valid;

  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
    sr_q[15:9] == 7'd0);

  assert_irq_wake_R7: assert property (@(posedge clk) disable iff (rst)
    (irq_take && sr_q[3]) |=> (!sr_q[3] && !sr_q[4]));

  assert_ext_osc_R8: assert property (@(posedge clk) disable iff (rst)
    (irq_take && irq_ext && sr_q[3]) |=> !sr_q[5]);

  assert_masked_irq_R9: assert property (@(posedge clk) disable iff (rst)
    (irq_take && !sr_q[3] && no_src) |=> $stable(sr_q));

  assert_reti_gie_R10: assert property (@(posedge clk) disable iff (rst)
    (reti_valid && !(irq_take && sr_q[3])) |=> sr_q[3]);

  assert_add_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    (alu_valid && !alu_sub && !sw_we && !reti_valid &&
     alu_a_sign == alu_b_sign && alu_res_msb != alu_a_sign) |=> sr_q[8]);
endmodule

bind cpu_status_reg psr_checker u_chk (
  .clk(clk), .rst(rst), .alu_valid(alu_valid), .alu_sub(alu_sub),
  .alu_a_sign(alu_a_sign), .alu_b_sign(alu_b_sign),
  .alu_res_msb(alu_res[DATA_W-1]), .sw_we(sw_we), .irq_take(irq_take),
  .irq_ext(irq_ext), .reti_valid(reti_valid), .sr_q(sr_q)
);

// File: tb/cpu_status_reg_bench.sv
module cpu_status_reg_bench;
  logic clk = 1'b0;
  logic rst;
  logic alu_valid, alu_sub, alu_a_sign, alu_b_sign, alu_cout;
  logic [15:0] alu_res;
  logic sw_we, irq_take, irq_ext, reti_valid;
  logic [15:0] sw_data, reti_data;
  logic [15:0] sr_q;
  logic core_halt, osc_off;
  logic [1:0] clk_gen_ctl;
  int total = 0;
  int bad = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  cpu_status_reg u_cpu_status_reg (
    .clk(clk), .rst(rst), .alu_valid(alu_valid), .alu_sub(alu_sub),
    .alu_a_sign(alu_a_sign), .alu_b_sign(alu_b_sign), .alu_res(alu_res),
    .alu_cout(alu_cout), .sw_we(sw_we), .sw_data(sw_data),
    .irq_take(irq_take), .irq_ext(irq_ext), .reti_valid(reti_valid),
    .reti_data(reti_data), .sr_q(sr_q), .core_halt(core_halt),
    .osc_off(osc_off), .clk_gen_ctl(clk_gen_ctl)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    alu_valid = 0; alu_sub = 0; alu_a_sign = 0; alu_b_sign = 0;
    alu_res = '0; alu_cout = 0; sw_we = 0; sw_data = '0;
    irq_take = 0; irq_ext = 0; reti_valid = 0; reti_data = '0;
  endtask

  // Inputs set at negedge, one posedge, then sampled at the following negedge.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic load(logic [15:0] v);
    sw_we = 1; sw_data = v; step();
  endtask

  task automatic alu_op(logic sub, logic [15:0] a, logic [15:0] b,
                        logic [15:0] r, logic c);
    alu_valid = 1; alu_sub = sub; alu_a_sign = a[15]; alu_b_sign = b[15];
    alu_res = r; alu_cout = c; step();
  endtask

  task automatic t_reset();
    check("R1 sr", sr_q, 16'h0000);
    check("R1 outs", {13'd0, core_halt, osc_off, clk_gen_ctl == 2'd0 ? 1'b0 : 1'b1}, 16'h0);
  endtask

  task automatic t_sw_write();
    load(16'hFFFF);
    check("R2 R5 write", sr_q, 16'h01FF);
    check("R5 outs", {12'd0, core_halt, osc_off, clk_gen_ctl}, 16'h000F);
    load(16'h0040);
    check("R5 scg0", {14'd0, clk_gen_ctl}, 16'h0001);
  endtask

  task automatic t_alu();
    load(16'h00F8);
    alu_op(0, 16'h7000, 16'h1000, 16'h8000, 0);
    check("R3 R4 pos overflow", sr_q, 16'h01FC);
    alu_op(0, 16'h8000, 16'h8000, 16'h0000, 1);
    check("R3 R4 neg overflow zero", sr_q, 16'h01FB);
    alu_op(0, 16'h0001, 16'h0001, 16'h0002, 0);
    check("R3 R4 plain add", sr_q, 16'h00F8);
    alu_op(1, 16'h8000, 16'h0001, 16'h7FFF, 1);
    check("R4 sub overflow", sr_q, 16'h01F9);
    alu_op(1, 16'h0005, 16'h0003, 16'h0002, 1);
    check("R4 sub no overflow", sr_q, 16'h00F9);
    alu_op(1, 16'h8000, 16'h8000, 16'h0000, 1);
    check("R3 R4 sub zero same sign", sr_q, 16'h00FB);
  endtask

  task automatic t_sw_over_alu();
    load(16'h0000);
    sw_we = 1; sw_data = 16'h0010;
    alu_valid = 1; alu_res = 16'h0000; alu_cout = 1;
    step();
    check("R6 sw beats alu", sr_q, 16'h0010);
  endtask

  task automatic t_irq();
    load(16'h00F8);
    irq_take = 1; irq_ext = 0; step();
    check("R7 internal irq", sr_q, 16'h00E0);
    check("R8 osc kept", {15'd0, osc_off}, 16'h0001);
    load(16'h00F8);
    irq_take = 1; irq_ext = 1; step();
    check("R8 external irq", sr_q, 16'h00C0);
    load(16'h0030);
    irq_take = 1; irq_ext = 1; step();
    check("R9 masked irq", sr_q, 16'h0030);
  endtask

  task automatic t_reti();
    load(16'h00C0);
    reti_valid = 1; reti_data = 16'hFE35; step();
    check("R10 R2 restore", sr_q, 16'h003D);
    check("R10 power outs", {14'd0, core_halt, osc_off}, 16'h0003);
  endtask

  task automatic t_collisions();
    load(16'h0008);
    irq_take = 1; irq_ext = 1; sw_we = 1; sw_data = 16'h01FF; step();
    check("R11 irq beats sw", sr_q, 16'h01C7);
    load(16'h0000);
    reti_valid = 1; reti_data = 16'h0003; sw_we = 1; sw_data = 16'h0100;
    alu_valid = 1; alu_res = 16'h8000; step();
    check("R12 reti beats sw alu", sr_q, 16'h000B);
  endtask

  initial begin
    idle();
    rst = 1;
    @(negedge clk); @(negedge clk);
    rst = 0;
    t_reset();
    t_sw_write();
    t_alu();
    t_sw_over_alu();
    t_irq();
    t_reti();
    t_collisions();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule